// File: doc/BRIEF.md
# Match-Compare Timer with Prescaled Counter

This block is a register-mapped interval timer. An up-counter advances at the input clock rate divided by a programmable factor of 1 to 4. It is compared against a programmable match value. When the count reaches that value while the timer is running, the block emits a single-cycle interrupt pulse. An optional auto-reload bit sends the count back to zero at the match, so the timer repeats with a fixed period. Left free, the counter wraps through zero.

Software resets the count by writing any value to a clear register. The reset does not take effect at once. It is carried out by a small sequencer with two states. In `CLR_IDLE` nothing is pending, and a clear write takes the sequencer to `CLR_WAIT`, loading a wait count. In `CLR_WAIT` the count is frozen and a pending flag is visible in the status register. A further clear write reloads the wait count and stays in `CLR_WAIT`. When the wait count is exhausted, the sequencer zeroes the count, restarts the divider phase and returns to `CLR_IDLE`. Software is expected to poll the pending flag before it re-enables the timer.

The register port is a plain single-cycle write strobe with a byte address. Reads are combinational from the address.

Top module: `mtimer`

## Requirements
- R1: After reset every register reads zero: match, count, control, divider and status. The interrupt output is low.
- R2: The byte offsets are as follows. 0x00 is the match value, read/write. 0x04 is the count, read-only, and writes to it are ignored. 0x08 is control, where bit 0 is run and bit 1 is auto-reload. 0x0C is clear, write-only, and reads as zero. 0x10 is the divider, bits 1:0. 0x14 is status, where bit 10 is the clear-pending flag. Any other offset reads zero.
- R3: While run is 0, the count holds its value and no interrupt pulse is produced, even if the match value is written equal to the count.
- R4: The divider field holds N-1 for a division by N. While running, the count advances once every N clocks. The divider phase restarts at zero when the divider is written, while run is 0, and when a clear completes.
- R5: A write of any data to offset 0x0C sets the pending flag in the next cycle. The flag stays set for exactly 3 cycles, and the count is frozen throughout. When the flag drops, the count reads zero. A clear write while the flag is set restarts the 3-cycle window.
- R6: The interrupt is a one-cycle pulse in the cycle after the count first equals the match value, while running with no clear pending. It does not repeat while the equality persists.
- R7: With auto-reload set, a count step taken while the count equals the match value loads zero instead of incrementing.
- R8: Without auto-reload, the count wraps from all ones (2^CNT_W-1) to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset for the read or write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data selected by addr |
| irq | output | 1 | Match interrupt pulse |

## Verification
A corrupted divider phase shows up in the count read-back within one division period, as a step that arrives early or late. A wrong clear-sequencer state shows at once in status bit 10. It also shows when the count fails to freeze or to return to zero in the cycle the flag drops. An error in the match-edge memory shows at the interrupt pin, either as a repeated pulse or a missing one, in the cycle after the count reaches the match value. The bench reads the count or status in every cycle and compares the interrupt pin in every cycle against a behavioural model, so each of these faults is caught in the cycle it first appears.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
    localparam logic [7:0] OFS_MATCH  = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h04;
    localparam logic [7:0] OFS_CTRL   = 8'h08;
    localparam logic [7:0] OFS_CLEAR  = 8'h0C;
    localparam logic [7:0] OFS_DIV    = 8'h10;
    localparam logic [7:0] OFS_STATUS = 8'h14;

    typedef enum logic {
        CLR_IDLE,
        CLR_WAIT
    } clr_state_t;
endpackage

// File: rtl/mtimer_regs.sv
module mtimer_regs
    import mtimer_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int ADDR_W   = 5,
    parameter int DIV_W    = 2,
    parameter int PEND_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              pend,
    output logic [CNT_W-1:0]  match_val,
    output logic              run,
    output logic              auto_clr,
    output logic [DIV_W-1:0]  div_sel,
    output logic              div_wr,
    output logic              clr_wr,
    output logic [31:0]       rdata
);
    localparam logic [ADDR_W-1:0] A_MATCH  = OFS_MATCH[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_COUNT  = OFS_COUNT[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_CTRL   = OFS_CTRL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_CLEAR  = OFS_CLEAR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_DIV    = OFS_DIV[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_STATUS = OFS_STATUS[ADDR_W-1:0];

    assign div_wr = wr_en && (addr == A_DIV);
    assign clr_wr = wr_en && (addr == A_CLEAR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_val <= '0;
            run       <= 1'b0;
            auto_clr  <= 1'b0;
            div_sel   <= '0;
        end else if (wr_en) begin
            if (addr == A_MATCH) match_val <= wdata[CNT_W-1:0];
            if (addr == A_CTRL) begin
                run      <= wdata[0];
                auto_clr <= wdata[1];
            end
            if (addr == A_DIV) div_sel <= wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MATCH)  rdata = 32'(match_val);
        if (addr == A_COUNT)  rdata = 32'(count);
        if (addr == A_CTRL)   rdata = {30'd0, auto_clr, run};
        if (addr == A_DIV)    rdata = 32'(div_sel);
        if (addr == A_STATUS) rdata[PEND_BIT] = pend;
    end

    // R2: the count offset is read-only; a write there leaves the match value unchanged
    assert_count_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_COUNT) |=> (match_val == $past(match_val)))
        else $error("count offset write altered a register");
endmodule

// File: rtl/mtimer_clear.sv
module mtimer_clear
    import mtimer_pkg::*;
#(
    parameter int CLR_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_wr,
    output logic pend,
    output logic clr_done
);
    localparam int WW = $clog2(CLR_CYC + 1);

    clr_state_t    state, state_nx;
    logic [WW-1:0] wcnt, wcnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CLR_IDLE;
            wcnt  <= '0;
        end else begin
            state <= state_nx;
            wcnt  <= wcnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        wcnt_nx  = wcnt;
        unique case (state)
            CLR_IDLE: begin
                if (clr_wr) begin
                    state_nx = CLR_WAIT;
                    wcnt_nx  = WW'(CLR_CYC - 1);
                end
            end
            CLR_WAIT: begin
                if (clr_wr) begin
                    wcnt_nx = WW'(CLR_CYC - 1);
                end else if (wcnt == '0) begin
                    state_nx = CLR_IDLE;
                end else begin
                    wcnt_nx = wcnt - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        pend     = (state == CLR_WAIT);
        clr_done = (state == CLR_WAIT) && !clr_wr && (wcnt == '0);
    end

    assert_clear_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> pend)
        else $error("clear write did not raise pending");
    assert_done_drops_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done |=> !pend)
        else $error("pending stayed high after completion");
endmodule

// File: rtl/mtimer_presc.sv
module mtimer_presc #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    logic [DIV_W-1:0] phase;

    assign tick = run && !hold && (phase == div_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               phase <= '0;
        else if (restart || !run) phase <= '0;
        else if (hold)            phase <= phase;
        else if (tick)            phase <= '0;
        else                      phase <= phase + 1'b1;
    end

    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel != '0 && !restart) |=> !tick)
        else $error("count steps closer than the divide ratio");
endmodule

// File: rtl/mtimer_count.sv
module mtimer_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             hold,
    input  logic             clr_done,
    input  logic             auto_clr,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic hit, hit_q;

    assign hit = run && !hold && (count == match_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr_done) begin
            count <= '0;
        end else if (tick) begin
            if (auto_clr && (count == match_val)) count <= '0;
            else                                  count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            hit_q <= hit;
            irq   <= hit && !hit_q;
        end
    end

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq)
        else $error("interrupt longer than one cycle");
    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr_done) |=> (count == $past(count)))
        else $error("count moved while stopped");
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !irq)
        else $error("interrupt while stopped");
    assert_auto_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && auto_clr && count == match_val && !clr_done) |=> (count == '0))
        else $error("auto-reload did not zero the count");
    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_done && (&count) && !(auto_clr && count == match_val)) |=> (count == '0))
        else $error("count did not wrap to zero");
endmodule

// File: rtl/mtimer.sv
module mtimer #(
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 5,
    parameter int DIV_W   = 2,
    parameter int CLR_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    logic [CNT_W-1:0] count, match_val;
    logic [DIV_W-1:0] div_sel;
    logic run, auto_clr, div_wr, clr_wr, pend, clr_done, tick;

    mtimer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .PEND_BIT(10)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count(count), .pend(pend), .match_val(match_val), .run(run),
        .auto_clr(auto_clr), .div_sel(div_sel), .div_wr(div_wr),
        .clr_wr(clr_wr), .rdata(rdata)
    );

    mtimer_clear #(.CLR_CYC(CLR_CYC)) u_clear (
        .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .pend(pend), .clr_done(clr_done)
    );

    mtimer_presc #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .hold(pend),
        .restart(div_wr || clr_done), .div_sel(div_sel), .tick(tick)
    );

    mtimer_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .hold(pend),
        .clr_done(clr_done), .auto_clr(auto_clr), .match_val(match_val),
        .count(count), .irq(irq)
    );

    assert_clear_lands_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> (count == '0))
        else $error("count nonzero when pending dropped");
endmodule

// File: tb/test_mtimer.sv
module test_mtimer;
    localparam int CW   = 8;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #5 clk = ~clk;

    mtimer #(.CNT_W(CW), .ADDR_W(5), .DIV_W(2), .CLR_CYC(3)) i_mtimer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    int tests = 0, fails = 0;
    bit finished = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_match = 0, m_count = 0, m_run = 0, m_auto = 0, m_div = 0;
    int m_phase = 0, m_left = 0, m_hitprev = 0, m_irq = 0;

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    function automatic int model_rd(input int a);
        case (a)
            'h00: return m_match;
            'h04: return m_count;
            'h08: return (m_auto << 1) | m_run;
            'h10: return m_div;
            'h14: return (m_left > 0) ? (1 << 10) : 0;
            default: return 0;
        endcase
    endfunction

    task automatic step(input bit wr, input int a, input int d);
        int n_match, n_count, n_run, n_auto, n_div, n_phase, n_left, n_hit, n_irq;
        bit pend, done, tick, clrw, divw;
        @(negedge clk);
        wr_en = wr; addr = a[4:0]; wdata = d;
        clrw = wr && a == 'h0C;
        divw = wr && a == 'h10;
        pend = m_left > 0;
        done = (m_left == 1) && !clrw;
        tick = m_run && !pend && (m_phase == m_div);
        n_hit = (m_run && !pend && m_count == m_match) ? 1 : 0;
        n_irq = (n_hit && !m_hitprev) ? 1 : 0;
        n_match = (wr && a == 'h00) ? (d & MASK) : m_match;
        n_run   = (wr && a == 'h08) ? (d & 1) : m_run;
        n_auto  = (wr && a == 'h08) ? ((d >> 1) & 1) : m_auto;
        n_div   = divw ? (d & 3) : m_div;
        if (clrw) n_left = 3;
        else if (m_left > 0) n_left = m_left - 1;
        else n_left = 0;
        if (done) n_count = 0;
        else if (tick) n_count = (m_auto && m_count == m_match) ? 0 : ((m_count + 1) & MASK);
        else n_count = m_count;
        if (divw || !m_run || done) n_phase = 0;
        else if (pend) n_phase = m_phase;
        else if (tick) n_phase = 0;
        else n_phase = m_phase + 1;
        @(posedge clk); #1;
        m_match = n_match; m_count = n_count; m_run = n_run; m_auto = n_auto;
        m_div = n_div; m_phase = n_phase; m_left = n_left;
        m_hitprev = n_hit; m_irq = n_irq;
        chk(cur_req, "rdata", rdata, model_rd(a));
        chk(cur_req, "irq", irq, m_irq);
    endtask

    task automatic idle(input int n, input int a);
        for (int i = 0; i < n; i++) step(0, a, 0);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        cur_req = "R1";
        chk("R1", "irq at reset", irq, 0);
        step(0, 'h00, 0); step(0, 'h04, 0); step(0, 'h08, 0);
        step(0, 'h10, 0); step(0, 'h14, 0);
        // R6: match pulse
        cur_req = "R6";
        step(1, 'h00, 5); step(1, 'h08, 1);
        idle(14, 'h04);
        // R3: stop and hold, no pulse on a match written while stopped
        cur_req = "R3";
        step(1, 'h08, 0); idle(5, 'h04);
        step(1, 'h00, m_count); idle(5, 'h04); step(0, 'h08, 0);
        // R2: count offset read-only, unmapped offsets
        cur_req = "R2";
        step(1, 'h04, 'hFF); step(0, 'h04, 0); step(0, 'h00, 0);
        step(0, 'h18, 0); step(0, 'h1C, 0); step(0, 'h01, 0); step(0, 'h0C, 0);
        // R4: divider ratios
        cur_req = "R4";
        step(1, 'h10, 3); step(1, 'h00, 200); step(1, 'h08, 1);
        idle(20, 'h04);
        step(1, 'h10, 1); idle(10, 'h04);
        step(1, 'h10, 2); idle(10, 'h04); step(0, 'h10, 0);
        // R7: auto-reload period
        cur_req = "R7";
        step(1, 'h10, 0); step(1, 'h00, 3); step(1, 'h08, 3);
        idle(20, 'h04);
        // R5: clear sequence and restart of the window
        cur_req = "R5";
        step(1, 'h0C, 'hDEAD); idle(5, 'h14);
        step(1, 'h0C, 0); step(0, 'h14, 0); step(1, 'h0C, 7);
        idle(6, 'h14); idle(4, 'h04);
        step(1, 'h0C, 1); step(0, 'h04, 0); step(0, 'h04, 0); step(0, 'h04, 0);
        step(0, 'h04, 0);
        // R8: wrap without auto-reload
        cur_req = "R8";
        step(1, 'h08, 0); step(1, 'h0C, 0); idle(4, 'h14);
        step(1, 'h00, 'h80); step(1, 'h08, 1);
        idle(300, 'h04);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule